// File: doc/BRIEF.md
# Hot-Swap Start-Up Qualification Controller

This block decides when the power switch of a hot-pluggable card may be turned on, and when it must be turned off again. It watches digital flags from outside comparators: two active-low card-seated detects, a master enable, an under-voltage-OK flag and an over-voltage flag. All start conditions must hold together and without a break for a selectable qualification delay before the gate-enable request is raised. Any break during that window starts the delay over from zero.

Once the switch is on, losing the master enable, losing a seated detect or a fault-clear request turns it off on the next clock. A supply excursion either turns it off on the next clock (filter off) or, with the filter on, only after the excursion has lasted the filter time. In that case the fault flag is set and the switch stays off until a fault clear is requested. A `qualified` status tells downstream power-good sequencing that the switch is on and the supply is in range at this moment.

All delays are counted in ticks from an internal prescaler, one tick per half millisecond. Configuration straps are captured while reset is held and are ignored afterwards.

Top module: `hsq_ctrl`

## Requirements
- R1: While and directly after reset, `gate_en`, `fault` and `qualified` are low.
- R2: `gate_en` rises only after the start conditions have held together without a break for the qualification delay. The conditions are: `pd_a_n` and `pd_b_n` both low (when pin detects are used), `master_en` high, `uv_ok` high, `ov_flag` low and `fault_clr` low.
- R3: `qual_sel` selects the qualification delay: 2'b00 gives 160 ticks (80 ms, default), 2'b01 gives 1 tick (0.5 ms), 2'b10 gives 10 ticks (5 ms) and 2'b11 gives 320 ticks (160 ms).
- R4: With `pd_use` low at reset, the pin-detect inputs have no effect on qualification or on an enabled switch.
- R5: A break in any start condition during qualification restarts the delay count from zero.
- R6: With `filt_sel` = 2'b00 (filter off), `uv_ok` low or `ov_flag` high while on drops `gate_en` on the next clock and leaves `fault` low.
- R7: While on, `master_en` low or either pin detect high (when used) drops `gate_en` on the next clock.
- R8: With the filter on (`filt_sel` 2'b01 = 10 ticks, 2'b10 = 160 ticks, 2'b11 = 320 ticks), a supply excursion shorter than the filter time leaves `gate_en` high. One that lasts the filter time drops `gate_en` and raises `fault`.
- R9: A latched fault holds `fault` high and `gate_en` low until `fault_clr` is asserted, whatever the other inputs do.
- R10: `fault_clr` clears `fault` on the next clock. After it is released, a new start needs a fresh full qualification delay.
- R11: `qualified` is high only while `gate_en` is high and the supply is in range. It drops in the same cycle a supply excursion appears, even while the filter holds `gate_en`.
- R12: `qual_sel`, `filt_sel` and `pd_use` are sampled only while `rst_n` is low. Later changes have no effect.
- R13: `fault_clr` asserted while on drops `gate_en` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the straps |
| pd_a_n | input | 1 | First card-seated detect, active low |
| pd_b_n | input | 1 | Second card-seated detect, active low |
| master_en | input | 1 | Master enable, active high |
| uv_ok | input | 1 | Supply above the under-voltage threshold |
| ov_flag | input | 1 | Supply above the over-voltage threshold |
| fault_clr | input | 1 | Fault-clear request, active high; also holds the switch off |
| qual_sel | input | 2 | Qualification delay strap |
| filt_sel | input | 2 | Supply-fault filter strap (2'b00 = off) |
| pd_use | input | 1 | Strap: 1 = pin detects required |
| gate_en | output | 1 | Request to turn the power switch on |
| fault | output | 1 | Latched supply fault |
| qualified | output | 1 | Switch on and supply in range |

## Verification
Two things can fall on the same clock: the end of the supply filter window, and a supply excursion that is still running while `qualified` has already dropped but `gate_en` is held. The bench holds an excursion from a known negedge and samples a few cycles before and after the earliest and latest tick-aligned expiry. It then judges `gate_en`, `fault` and `qualified` together, so a late latch, an early latch or a missing fault all show up. The same bracketing judges the qualification delay after breaks, after a fault clear and for every delay strap.

// File: rtl/hsq_pkg.sv
// Package: shared types for the hot-swap qualification controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hsq_pkg;

    // Controller states: waiting to qualify, switch on, latched supply fault.
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_ON    = 2'd1,
        ST_LATCH = 2'd2
    } hsq_state_t;

    // Largest of two integers, for deriving counter widths.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hsq_tick_gen.sv
// Module: hsq_tick_gen
// Produces a one-clock tick every TICK_DIV clocks (one tick = 0.5 ms in use).
// Assumes: TICK_DIV >= 1; the tick is free running from reset.
module hsq_tick_gen #(
    parameter int TICK_DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV == 1) begin : g_pass
            // Every clock is a tick when no division is asked for.
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] div_q;

            // Wrap-around divider counter.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == DW'(TICK_DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == DW'(TICK_DIV - 1));

            a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick held for two clocks");
        end
    endgenerate
endmodule

// File: rtl/hsq_window_timer.sv
// Module: hsq_window_timer
// Counts ticks while 'run' holds; any cycle without 'run' clears the count.
// 'done' is high while running with the count at the limit (saturating).
// Assumes: limit >= 1 and stable after reset.
module hsq_window_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Tick counter: restart on any break, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (tick && (cnt_q != limit))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == limit);

    // R5: a break leaves the count at zero for the next cycle.
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0))
        else $error("window count survived a break");

    // R3: the count never passes the selected limit.
    a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit)
        else $error("window count passed its limit");
endmodule

// File: rtl/hsq_fsm.sv
// Module: hsq_fsm
// Wait / on / latched-fault sequencer of the qualification controller.
// Assumes: inputs are synchronous to clk; timer 'done' flags come from
// hsq_window_timer instances gated by this module's state.
module hsq_fsm
    import hsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_ok,
    input  logic       pd_ok,
    input  logic       master_en,
    input  logic       supply_ok,
    input  logic       fault_clr,
    input  logic       filt_on,
    input  logic       qual_done,
    input  logic       filt_done,
    output hsq_state_t state
);
    hsq_state_t state_d;

    // Next-state decision.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_WAIT: begin
                if (qual_done)
                    state_d = ST_ON;
            end
            ST_ON: begin
                if (fault_clr || !pd_ok || !master_en)
                    state_d = ST_WAIT;
                else if (!supply_ok) begin
                    if (!filt_on)
                        state_d = ST_WAIT;
                    else if (filt_done)
                        state_d = ST_LATCH;
                end
            end
            ST_LATCH: begin
                if (fault_clr)
                    state_d = ST_WAIT;
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_WAIT;
        else
            state <= state_d;
    end

    // R6: unfiltered supply excursion turns the switch off at once, no fault.
    a_r6_unfiltered_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && !supply_ok && !filt_on) |=> (state == ST_WAIT))
        else $error("unfiltered supply fault did not turn off");

    // R7: enable or seating loss turns the switch off at once.
    a_r7_enable_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && (!master_en || !pd_ok)) |=> (state == ST_WAIT))
        else $error("enable loss did not turn off");

    // R9: a latched fault holds until cleared.
    a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && !fault_clr) |=> (state == ST_LATCH))
        else $error("latched fault released without clear");

    // R10: a clear leaves the latch into the waiting state, never straight on.
    a_r10_clear_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCH && fault_clr) |=> (state == ST_WAIT))
        else $error("fault clear did not return to wait");

    // R13: a clear request while on turns the switch off.
    a_r13_clear_while_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ON && fault_clr) |=> (state == ST_WAIT))
        else $error("clear while on kept the switch on");
endmodule

// File: rtl/hsq_ctrl.sv
// Module: hsq_ctrl (top)
// Hot-swap start-up qualification controller: captures straps at reset,
// times a continuous qualification window and an optional supply filter,
// and drives gate enable, latched fault and qualified status.
// Assumes: all inputs synchronous to clk; one tick = 0.5 ms.
module hsq_ctrl
    import hsq_pkg::*;
#(
    parameter int TICK_DIV = 125000,
    parameter int Q_DEF    = 160,
    parameter int Q_SHORT  = 1,
    parameter int Q_MID    = 10,
    parameter int Q_LONG   = 320,
    parameter int F_SHORT  = 10,
    parameter int F_MID    = 160,
    parameter int F_LONG   = 320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_a_n,
    input  logic       pd_b_n,
    input  logic       master_en,
    input  logic       uv_ok,
    input  logic       ov_flag,
    input  logic       fault_clr,
    input  logic [1:0] qual_sel,
    input  logic [1:0] filt_sel,
    input  logic       pd_use,
    output logic       gate_en,
    output logic       fault,
    output logic       qualified
);
    localparam int MAX_Q = imax(imax(Q_DEF, Q_SHORT), imax(Q_MID, Q_LONG));
    localparam int MAX_F = imax(F_SHORT, imax(F_MID, F_LONG));
    localparam int CNT_W = $clog2(imax(MAX_Q, MAX_F) + 1);

    logic [1:0]       cfg_qsel;
    logic [1:0]       cfg_fsel;
    logic             cfg_pd_use;
    logic [CNT_W-1:0] qual_limit;
    logic [CNT_W-1:0] filt_limit;
    logic             filt_on;
    logic             tick;
    logic             pd_ok;
    logic             supply_ok;
    logic             start_ok;
    logic             qual_done;
    logic             filt_done;
    hsq_state_t       state;

    // Strap capture: straps are followed only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_qsel   <= qual_sel;
            cfg_fsel   <= filt_sel;
            cfg_pd_use <= pd_use;
        end
    end

    // Qualification delay lookup.
    always_comb begin
        unique case (cfg_qsel)
            2'b01:   qual_limit = CNT_W'(Q_SHORT);
            2'b10:   qual_limit = CNT_W'(Q_MID);
            2'b11:   qual_limit = CNT_W'(Q_LONG);
            default: qual_limit = CNT_W'(Q_DEF);
        endcase
    end

    // Supply filter lookup; code 00 turns the filter off.
    always_comb begin
        unique case (cfg_fsel)
            2'b10:   filt_limit = CNT_W'(F_MID);
            2'b11:   filt_limit = CNT_W'(F_LONG);
            default: filt_limit = CNT_W'(F_SHORT);
        endcase
    end

    assign filt_on   = (cfg_fsel != 2'b00);
    assign pd_ok     = !cfg_pd_use || (!pd_a_n && !pd_b_n);
    assign supply_ok = uv_ok && !ov_flag;
    assign start_ok  = pd_ok && master_en && supply_ok && !fault_clr;

    hsq_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    hsq_window_timer #(
        .CNT_W (CNT_W)
    ) u_qual_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   ((state == ST_WAIT) && start_ok),
        .limit (qual_limit),
        .done  (qual_done)
    );

    hsq_window_timer #(
        .CNT_W (CNT_W)
    ) u_filt_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   ((state == ST_ON) && filt_on && !supply_ok),
        .limit (filt_limit),
        .done  (filt_done)
    );

    hsq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .pd_ok     (pd_ok),
        .master_en (master_en),
        .supply_ok (supply_ok),
        .fault_clr (fault_clr),
        .filt_on   (filt_on),
        .qual_done (qual_done),
        .filt_done (filt_done),
        .state     (state)
    );

    assign gate_en   = (state == ST_ON);
    assign fault     = (state == ST_LATCH);
    assign qualified = gate_en && supply_ok;

    // R1: outputs low in the clock after a reset edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!gate_en && !fault && !qualified))
        else $error("outputs active after reset");

    // R2: the switch turns on only from a cycle where every condition held.
    a_r2_on_needs_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(start_ok))
        else $error("gate enabled without start conditions");

    // R8: a fault appears only out of the on state during a supply excursion.
    a_r8_fault_from_on: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> ($past(gate_en) && $past(!supply_ok)))
        else $error("fault raised outside a supply excursion");

    // R11: qualified implies the switch is on.
    a_r11_qualified_on: assert property (@(posedge clk) disable iff (!rst_n)
        qualified |-> (gate_en && !fault))
        else $error("qualified without switch on");

    // R12: straps stay frozen once reset is released.
    a_r12_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_qsel) && $stable(cfg_fsel) && $stable(cfg_pd_use))
        else $error("strap capture changed outside reset");
endmodule

// File: tb/hsq_ctrl_test.sv
`timescale 1ns/1ps
module hsq_ctrl_test;
    localparam int D = 4;   // clocks per tick in the bench

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pd_a_n, pd_b_n, master_en, uv_ok, ov_flag, fault_clr;
    logic [1:0] qual_sel, filt_sel;
    logic       pd_use;
    logic       gate_en, fault, qualified;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hsq_ctrl #(.TICK_DIV(D)) uut (
        .clk(clk), .rst_n(rst_n), .pd_a_n(pd_a_n), .pd_b_n(pd_b_n),
        .master_en(master_en), .uv_ok(uv_ok), .ov_flag(ov_flag),
        .fault_clr(fault_clr), .qual_sel(qual_sel), .filt_sel(filt_sel),
        .pd_use(pd_use), .gate_en(gate_en), .fault(fault), .qualified(qualified)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic all_good();
        pd_a_n = 0; pd_b_n = 0; master_en = 1; uv_ok = 1; ov_flag = 0; fault_clr = 0;
    endtask

    task automatic do_reset(input logic [1:0] qs, input logic [1:0] fs, input logic pu);
        @(negedge clk);
        rst_n = 0; qual_sel = qs; filt_sel = fs; pd_use = pu;
        pd_a_n = 1; pd_b_n = 1; master_en = 0; uv_ok = 0; ov_flag = 0; fault_clr = 0;
        cyc(3);
        rst_n = 1;
        cyc(1);
    endtask

    // Drive all start conditions and check the on-time bracket for n ticks.
    task automatic qualify(input string req, input int n);
        all_good();
        if (n > 1) begin
            cyc((n - 1) * D);
            chk(req, "gate before delay", gate_en, 1'b0);
            cyc(D + 4);
        end else begin
            cyc(D + 4);
        end
        chk(req, "gate after delay", gate_en, 1'b1);
    endtask

    task automatic t_reset();
        do_reset(2'b00, 2'b00, 1'b1);
        chk("R1", "gate", gate_en, 1'b0);
        chk("R1", "fault", fault, 1'b0);
        chk("R1", "qualified", qualified, 1'b0);
    endtask

    task automatic t_default_delay();   // R3 code 00 = 160 ticks
        do_reset(2'b00, 2'b00, 1'b1);
        qualify("R3", 160);
        chk("R11", "qualified when on", qualified, 1'b1);
    endtask

    task automatic t_other_delays();
        do_reset(2'b01, 2'b00, 1'b1); qualify("R3", 1);
        do_reset(2'b10, 2'b00, 1'b1); qualify("R3", 10);
        do_reset(2'b11, 2'b00, 1'b1); qualify("R3", 320);
    endtask

    task automatic t_partial_conditions();   // R2
        do_reset(2'b10, 2'b00, 1'b1);
        all_good(); pd_b_n = 1;
        cyc(60);
        chk("R2", "one detect missing", gate_en, 1'b0);
        pd_b_n = 0; ov_flag = 1;
        cyc(60);
        chk("R2", "over-voltage present", gate_en, 1'b0);
    endtask

    task automatic t_break_restart();   // R5
        do_reset(2'b00, 2'b00, 1'b1);
        all_good();
        cyc(400);
        master_en = 0;
        cyc(2);
        master_en = 1;
        cyc(500);
        chk("R5", "gate after break, short of new delay", gate_en, 1'b0);
        cyc(144);
        chk("R5", "gate after full new delay", gate_en, 1'b1);
    endtask

    task automatic t_enable_loss();   // R7, R13
        do_reset(2'b01, 2'b00, 1'b1);
        qualify("R7", 1);
        master_en = 0; cyc(1);
        chk("R7", "gate after master low", gate_en, 1'b0);
        qualify("R7", 1);
        pd_a_n = 1; cyc(1);
        chk("R7", "gate after detect lost", gate_en, 1'b0);
        qualify("R13", 1);
        fault_clr = 1; cyc(1);
        chk("R13", "gate after clear while on", gate_en, 1'b0);
        chk("R13", "fault after clear while on", fault, 1'b0);
    endtask

    task automatic t_unfiltered_supply();   // R6
        do_reset(2'b01, 2'b00, 1'b1);
        qualify("R6", 1);
        uv_ok = 0; #1;
        chk("R11", "qualified same cycle", qualified, 1'b0);
        cyc(1);
        chk("R6", "gate after under-voltage", gate_en, 1'b0);
        chk("R6", "no fault unfiltered", fault, 1'b0);
        qualify("R6", 1);
        ov_flag = 1; cyc(1);
        chk("R6", "gate after over-voltage", gate_en, 1'b0);
    endtask

    task automatic t_pd_unused();   // R4
        do_reset(2'b10, 2'b00, 1'b0);
        all_good(); pd_a_n = 1; pd_b_n = 1;
        cyc(44);
        chk("R4", "qualified without detects", gate_en, 1'b1);
        pd_a_n = 0; cyc(3); pd_a_n = 1; cyc(3);
        chk("R4", "detect toggle ignored", gate_en, 1'b1);
    endtask

    task automatic t_filter();   // R8 code 01 = 10 ticks, R9, R10, R11
        do_reset(2'b10, 2'b01, 1'b1);
        qualify("R8", 10);
        uv_ok = 0; #1;
        chk("R11", "qualified drops in filter window", qualified, 1'b0);
        cyc(20);
        chk("R8", "gate held in short excursion", gate_en, 1'b1);
        uv_ok = 1; cyc(2);
        chk("R8", "no fault after short excursion", fault, 1'b0);
        chk("R11", "qualified back", qualified, 1'b1);
        ov_flag = 1;
        cyc(34);
        chk("R8", "gate before filter end", gate_en, 1'b1);
        cyc(10);
        chk("R8", "gate after filter end", gate_en, 1'b0);
        chk("R8", "fault after filter end", fault, 1'b1);
        ov_flag = 0;
        cyc(80);
        chk("R9", "fault held", fault, 1'b1);
        chk("R9", "gate held off", gate_en, 1'b0);
        fault_clr = 1; cyc(1);
        chk("R10", "fault cleared", fault, 1'b0);
        cyc(60);
        chk("R10", "gate off while clear held", gate_en, 1'b0);
        fault_clr = 0;
        cyc(36);
        chk("R10", "gate before fresh delay", gate_en, 1'b0);
        cyc(8);
        chk("R10", "gate after fresh delay", gate_en, 1'b1);
    endtask

    task automatic t_strap_frozen();   // R12
        do_reset(2'b01, 2'b00, 1'b1);
        qual_sel = 2'b11; filt_sel = 2'b11; pd_use = 1'b0;
        qualify("R12", 1);
        uv_ok = 0; cyc(1);
        chk("R12", "filter strap ignored", gate_en, 1'b0);
        chk("R12", "no fault from ignored filter", fault, 1'b0);
        uv_ok = 1; pd_a_n = 1; cyc(40);
        chk("R12", "detect use strap ignored", gate_en, 1'b0);
    endtask

    initial begin
        rst_n = 0;
        t_reset();
        t_default_delay();
        t_other_delays();
        t_partial_conditions();
        t_break_restart();
        t_enable_loss();
        t_unfiltered_supply();
        t_pd_unused();
        t_filter();
        t_strap_frozen();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule